// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns the oscillator clock of an 8-bit controller into the strobe and port timing of its external memory bus. The address is 16 bits. Its low byte and the data share one byte-wide port, and a second port carries the high byte. Every machine cycle lasts twelve oscillator clocks and is split into two halves of six. The sequencer keeps the address-latch strobe running at one sixth of the oscillator rate. When code is fetched from outside, it issues one program-store strobe in each half. When a data transfer is requested, it gives a whole machine cycle to the read or the write.

The core tells the sequencer three things: whether each half-cycle fetches external code, the code address to fetch, and whether the latch-strobe disable bit is set. A data transfer is requested with a one-clock pulse. The pulse carries the direction, whether the high address comes from the 16-bit pointer or from the high port's register, the address, and the write byte. The sequencer holds such a request until the next machine-cycle boundary. It returns each fetched code byte with a one-clock valid pulse, and each finished transfer with a one-clock completion pulse and, for a read, the byte it read.

Top module: `ebus_ctrl`

## Requirements
- R1: While `rst` is high, `ale`=0, `psen_n`=1, `rd_n`=1, `wr_n`=1, `p0_oe`=0, `ivalid`=0 and `dvalid`=0.
- R2: Phase p (0..11) is the p-th clock after a machine-cycle boundary. The first cycle after reset starts on the first rising edge. Outside data cycles, `ale` is high in phases 0-1 and 6-7 of every machine cycle, so it runs at one sixth of the clock, for internal and external execution alike.
- R3: In a half-cycle whose `fetch_ext` was 1 at its start, `psen_n` is low for local phases 3-5 of that half. `p0_oe` is 1 and `p0_out` carries `code_addr[7:0]` in local phases 0-2, and `p2_out` carries `code_addr[15:8]`. `code_addr` is sampled at the start of the half. The byte on `p0_in` at the rising edge of `psen_n` appears on `ibyte`, with a one-clock `ivalid`.
- R4: In a half-cycle with internal execution, `psen_n` stays 1, `p0_oe` stays 0 and `p2_out` follows `p2_latch`.
- R5: A data machine cycle has `ale` high only in phases 0-1, so the pulse at phase 6 is skipped. Both program-store strobes are skipped.
- R6: A read holds `rd_n` low in phases 5-10 (six clocks), three clocks after `ale` falls. `p0_oe` is 1 with `addr[7:0]` in phases 0-2 and 0 from phase 3 on. The byte on `p0_in` at the rising edge of `rd_n` appears on `rbyte`, with `dvalid`=1 in phase 11.
- R7: A write holds `wr_n` low in phases 5-10. `p0_out` carries the write byte with `p0_oe`=1 from phase 3 to phase 11, and `dvalid`=1 in phase 11.
- R8: During a data cycle, `p2_out` carries `addr[15:8]` when `dwide`=1, and `p2_latch` when `dwide`=0.
- R9: With `ale_off`=1 at the start of a half, `ale` stays low in that half if it has internal execution and no data cycle. The disable has no effect in a half with external fetch or in the address half of a data cycle.
- R10: A request pulsed in any phase, including phase 11, starts the data cycle at the next machine-cycle boundary. The request fields are captured with the pulse, so later changes on those inputs have no effect.
- R11: `ale` is never high while `rd_n` or `wr_n` is low, and `psen_n` is never low together with either of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_ext | input | 1 | The coming half-cycle fetches external code |
| code_addr | input | 16 | Code fetch address for the coming half-cycle |
| ale_off | input | 1 | Latch-strobe disable bit |
| p2_latch | input | 8 | Contents of the high port's register |
| dreq | input | 1 | One-clock data transfer request |
| dwr | input | 1 | Request is a write (1) or a read (0) |
| dwide | input | 1 | High address from the 16-bit pointer (1) or from the port register (0) |
| daddr | input | 16 | Data address |
| dwdata | input | 8 | Write byte |
| p0_in | input | 8 | Value read back from the multiplexed port |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Drive value of the multiplexed port |
| p0_oe | output | 1 | Output enable of the multiplexed port |
| p2_out | output | 8 | High address port drive |
| ibyte | output | 8 | Fetched code byte |
| ivalid | output | 1 | One-clock pulse: `ibyte` is new |
| rbyte | output | 8 | Byte read by the last read cycle |
| dvalid | output | 1 | One-clock pulse: the data transfer is done |

## Verification
The strobes and port drives are decoded from the phase counter and the registers loaded at each half start. They therefore take their new value in the same clock in which the counter enters a phase, and the bench compares them at the falling edge of every phase of every cycle. `ivalid` and `ibyte` land one clock after the last program-store phase: phase 6 for the first half, and phase 0 of the next cycle for the second half. `dvalid` and `rbyte` land in phase 11, one clock after the last strobe phase. A request is seen as a data cycle exactly one machine cycle boundary later. The bench drives `p0_in` with a new value only after each capture edge and scrambles the request inputs right after each pulse, so a value sampled one clock off shows up as a mismatch.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int PH_W   = 4;

    typedef logic [PH_W-1:0] phase_t;

    // machine cycle of twelve clocks, two halves of six
    localparam phase_t PH_LAST   = 4'd11;
    localparam phase_t PH_HALF   = 4'd6;
    localparam phase_t HALF_LAST = 4'd5;
    localparam phase_t ALE_END   = 4'd1;   // ale high at local 0..1
    localparam phase_t ADR_END   = 4'd2;   // low address driven local 0..2
    localparam phase_t PS_BEG    = 4'd3;   // psen low local 3..5
    localparam phase_t RW_BEG    = 4'd5;   // rd/wr low 5..10
    localparam phase_t RW_END    = 4'd10;
    localparam phase_t WD_BEG    = 4'd3;   // write data 3..11

    typedef struct packed {
        logic              wr;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    function automatic logic ph_in(input phase_t p, input phase_t lo, input phase_t hi);
        return (p >= lo) && (p <= hi);
    endfunction

    function automatic phase_t ph_local(input phase_t p);
        return (p >= PH_HALF) ? phase_t'(p - PH_HALF) : p;
    endfunction

endpackage

// File: rtl/ebus_seq.sv
module ebus_seq
    import ebus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t ph,
    output logic   mc_end,
    output logic   half_end
);
    always_ff @(posedge clk) begin
        if (rst)         ph <= PH_LAST;
        else if (mc_end) ph <= '0;
        else             ph <= ph + 4'd1;
    end

    assign mc_end   = (ph == PH_LAST);
    assign half_end = (ph == PH_LAST) || (ph == HALF_LAST);
endmodule

// File: rtl/ebus_accept.sv
module ebus_accept
    import ebus_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  mc_end,
    input  logic  dreq,
    input  xfer_t req_in,
    output xfer_t act,
    output logic  dcyc
);
    xfer_t pend;
    logic  pend_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= '0;
            pend_v <= 1'b0;
            act    <= '0;
            dcyc   <= 1'b0;
        end else if (mc_end) begin
            dcyc   <= pend_v | dreq;
            pend_v <= 1'b0;
            if (pend_v)    act <= pend;
            else if (dreq) act <= req_in;
        end else if (dreq && !pend_v) begin
            pend   <= req_in;
            pend_v <= 1'b1;
        end
    end
endmodule

// File: rtl/ebus_pins.sv
module ebus_pins
    import ebus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_t            ph,
    input  logic              half_end,
    input  logic              dcyc,
    input  xfer_t             act,
    input  logic              fetch_ext,
    input  logic [ADDR_W-1:0] code_addr,
    input  logic              ale_off,
    input  logic [DATA_W-1:0] p2_latch,
    input  logic [DATA_W-1:0] p0_in,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [DATA_W-1:0] p2_out,
    output logic [DATA_W-1:0] ibyte,
    output logic              ivalid,
    output logic [DATA_W-1:0] rbyte,
    output logic              dvalid
);
    logic              ext_h, aoff_h;
    logic [ADDR_W-1:0] caddr_h;
    phase_t            hph;
    logic              second, rw_win, adr_win;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_h   <= 1'b0;
            aoff_h  <= 1'b0;
            caddr_h <= '0;
            ibyte   <= '0;
            ivalid  <= 1'b0;
            rbyte   <= '0;
            dvalid  <= 1'b0;
        end else begin
            if (half_end) begin
                ext_h   <= fetch_ext;
                aoff_h  <= ale_off;
                caddr_h <= code_addr;
            end
            ivalid <= half_end && ext_h && !dcyc;
            if (half_end && ext_h && !dcyc) ibyte <= p0_in;
            dvalid <= dcyc && (ph == RW_END);
            if (dcyc && !act.wr && (ph == RW_END)) rbyte <= p0_in;
        end
    end

    always_comb begin
        hph     = ph_local(ph);
        second  = (ph >= PH_HALF);
        rw_win  = dcyc && ph_in(ph, RW_BEG, RW_END);
        adr_win = (hph <= ADR_END);

        if (dcyc) ale = (hph <= ALE_END) && !second;
        else      ale = (hph <= ALE_END) && (ext_h || !aoff_h);

        psen_n = !(!dcyc && ext_h && (hph >= PS_BEG));
        rd_n   = !(rw_win && !act.wr);
        wr_n   = !(rw_win && act.wr);

        p0_oe  = 1'b0;
        p0_out = '0;
        if (dcyc) begin
            if (!second && adr_win) begin
                p0_oe  = 1'b1;
                p0_out = act.addr[DATA_W-1:0];
            end else if (act.wr && (ph >= WD_BEG)) begin
                p0_oe  = 1'b1;
                p0_out = act.wdata;
            end
        end else if (ext_h && adr_win) begin
            p0_oe  = 1'b1;
            p0_out = caddr_h[DATA_W-1:0];
        end

        if (dcyc)       p2_out = act.wide ? act.addr[ADDR_W-1:DATA_W] : p2_latch;
        else if (ext_h) p2_out = caddr_h[ADDR_W-1:DATA_W];
        else            p2_out = p2_latch;
    end
endmodule

// File: rtl/ebus_ctrl.sv
module ebus_ctrl
    import ebus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_ext,
    input  logic [ADDR_W-1:0] code_addr,
    input  logic              ale_off,
    input  logic [DATA_W-1:0] p2_latch,
    input  logic              dreq,
    input  logic              dwr,
    input  logic              dwide,
    input  logic [ADDR_W-1:0] daddr,
    input  logic [DATA_W-1:0] dwdata,
    input  logic [DATA_W-1:0] p0_in,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [DATA_W-1:0] p2_out,
    output logic [DATA_W-1:0] ibyte,
    output logic              ivalid,
    output logic [DATA_W-1:0] rbyte,
    output logic              dvalid
);
    phase_t ph;
    logic   mc_end, half_end, dcyc;
    xfer_t  req_in, act;

    assign req_in = '{wr: dwr, wide: dwide, addr: daddr, wdata: dwdata};

    ebus_seq u_seq (
        .clk(clk), .rst(rst), .ph(ph), .mc_end(mc_end), .half_end(half_end)
    );

    ebus_accept u_acc (
        .clk(clk), .rst(rst), .mc_end(mc_end), .dreq(dreq),
        .req_in(req_in), .act(act), .dcyc(dcyc)
    );

    ebus_pins u_pins (
        .clk(clk), .rst(rst), .ph(ph), .half_end(half_end), .dcyc(dcyc),
        .act(act), .fetch_ext(fetch_ext), .code_addr(code_addr),
        .ale_off(ale_off), .p2_latch(p2_latch), .p0_in(p0_in),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
        .ibyte(ibyte), .ivalid(ivalid), .rbyte(rbyte), .dvalid(dvalid)
    );
endmodule

// File: rtl/ebus_ctrl_chk.sv
module ebus_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n,
    input logic p0_oe,
    input logic ivalid,
    input logic dvalid
);
    // R11
    ale_vs_rw_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !ale);

    // R11
    psen_vs_rw_chk: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> (rd_n && wr_n));

    // R6
    float_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!psen_n || !rd_n) |-> !p0_oe);

    // R7
    write_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> p0_oe);

    // R2
    ale_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ale) |-> ($past(ale, 2) && !$past(ale, 3)));

    // R6
    rd_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n) |-> (!$past(rd_n, 6) && $past(rd_n, 7)));

    // R6
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        dvalid |-> (!$past(rd_n) || !$past(wr_n)));

    // R3
    ivalid_after_psen_chk: assert property (@(posedge clk) disable iff (rst)
        ivalid |-> $rose(psen_n));
endmodule

bind ebus_ctrl ebus_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .p0_oe(p0_oe), .ivalid(ivalid), .dvalid(dvalid)
);

// File: tb/ebus_ctrl_bench.sv
module ebus_ctrl_bench;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_ext = 1'b0, ale_off = 1'b0, dreq = 1'b0, dwr = 1'b0, dwide = 1'b0;
    logic [15:0] code_addr = '0, daddr = '0;
    logic [7:0]  p2_latch = '0, dwdata = '0, p0_in = '0;
    logic        ale, psen_n, rd_n, wr_n, p0_oe, ivalid, dvalid;
    logic [7:0]  p0_out, p2_out, ibyte, rbyte;

    always #(CLK_NS/2) clk = ~clk;

    ebus_ctrl u_ebus_ctrl (
        .clk(clk), .rst(rst), .fetch_ext(fetch_ext), .code_addr(code_addr),
        .ale_off(ale_off), .p2_latch(p2_latch), .dreq(dreq), .dwr(dwr),
        .dwide(dwide), .daddr(daddr), .dwdata(dwdata), .p0_in(p0_in),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
        .ibyte(ibyte), .ivalid(ivalid), .rbyte(rbyte), .dvalid(dvalid)
    );

    typedef struct {
        bit          v;
        bit          wr;
        bit          wide;
        logic [15:0] a;
        logic [7:0]  wd;
    } req_s;

    int   checks = 0, fails = 0;
    bit   finished = 1'b0;
    bit   prev_e1 = 1'b0, prev_dc = 1'b0;
    logic [7:0] prev_din = '0;
    req_s cur = '{0, 0, 0, 16'h0, 8'h0};

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one machine cycle; rph<0 means no request, else pulse in that phase
    task automatic run_cycle(input bit e0, input bit e1, input bit aoff,
                             input logic [7:0] p2r, input int rph,
                             input req_s r, input logic [7:0] din);
        bit          dc = cur.v;
        logic [15:0] c0 = {din, ~din};
        logic [15:0] c1 = {~din, din ^ 8'h5a};
        req_s        nxt = '{0, 0, 0, 16'h0, 8'h0};
        fetch_ext = e0;
        code_addr = c0;
        ale_off   = aoff;
        p2_latch  = p2r;
        for (int ph = 0; ph < 12; ph++) begin
            int          l   = ph % 6;
            bit          sec = (ph >= 6);
            bit          eh  = sec ? e1 : e0;
            logic [15:0] ca  = sec ? c1 : c0;
            bit          e_ale, e_psen, rw, e_oe, e_iv;
            logic [7:0]  e_p0, e_p2;
            @(posedge clk);
            @(negedge clk);
            e_ale = dc ? (!sec && l < 2) : (l < 2 && (eh || !aoff));
            chk(dc ? "R5" : (aoff && !eh) ? "R9" : "R2", "ale", ale, e_ale);
            e_psen = !(!dc && eh && l >= 3);
            chk(dc ? "R5" : eh ? "R3" : "R4", "psen_n", psen_n, e_psen);
            rw = dc && ph >= 5 && ph <= 10;
            chk("R6", "rd_n", rd_n, !(rw && !cur.wr));
            chk("R7", "wr_n", wr_n, !(rw && cur.wr));
            if (dc && ph == 5)
                chk("R10", "strobe", {rd_n, wr_n}, cur.wr ? 2'b10 : 2'b01);
            e_oe = 1'b0; e_p0 = '0;
            if (dc) begin
                if (!sec && l <= 2) begin e_oe = 1'b1; e_p0 = cur.a[7:0]; end
                else if (cur.wr && ph >= 3) begin e_oe = 1'b1; e_p0 = cur.wd; end
            end else if (eh && l <= 2) begin
                e_oe = 1'b1; e_p0 = ca[7:0];
            end
            chk(dc ? (cur.wr ? "R7" : "R6") : eh ? "R3" : "R4", "p0_oe", p0_oe, e_oe);
            if (e_oe) chk(dc ? (cur.wr ? "R7" : "R6") : "R3", "p0_out", p0_out, e_p0);
            e_p2 = dc ? (cur.wide ? cur.a[15:8] : p2r) : eh ? ca[15:8] : p2r;
            chk(dc ? "R8" : eh ? "R3" : "R4", "p2_out", p2_out, e_p2);
            e_iv = (ph == 6 && e0 && !dc) || (ph == 0 && prev_e1 && !prev_dc);
            chk("R3", "ivalid", ivalid, e_iv);
            if (e_iv) chk("R3", "ibyte", ibyte, (ph == 6) ? din : prev_din);
            chk(cur.wr ? "R7" : "R6", "dvalid", dvalid, dc && ph == 11);
            if (dc && !cur.wr && ph == 11) chk("R6", "rbyte", rbyte, din);
            // stimulus for the next edge
            if (ph == 0) p0_in = din;
            if (ph == 5) begin fetch_ext = e1; code_addr = c1; end
            if (ph == rph) begin
                dreq = 1'b1; dwr = r.wr; dwide = r.wide; daddr = r.a; dwdata = r.wd;
                nxt = r; nxt.v = 1'b1;
            end else begin
                dreq = 1'b0; dwr = ~dwr; dwide = ~dwide;
                daddr = ~daddr; dwdata = dwdata + 8'h3b;
            end
        end
        prev_e1  = e1;
        prev_dc  = dc;
        prev_din = din;
        cur      = nxt;
    endtask

    initial begin
        req_s none = '{0, 0, 0, 16'h0, 8'h0};
        int   rtab[4] = '{0, 4, 9, 11};
        repeat (3) @(negedge clk);
        chk("R1", "reset strobes", {ale, psen_n, rd_n, wr_n, p0_oe, ivalid, dvalid},
            7'b0111000);
        rst = 1'b0;
        for (int e = 0; e < 8; e++)
            run_cycle(e[0], e[1], e[2], 8'h40 + 8'(e), -1, none, 8'h11 * 8'(e + 1));
        for (int k = 0; k < 16; k++) begin
            req_s r;
            r.v = 1'b1; r.wr = k[0]; r.wide = k[1];
            r.a = 16'h1234 + 16'(k) * 16'h0f1; r.wd = 8'hc3 ^ 8'(k * 7);
            run_cycle(!k[0], 1'b1, k[2], 8'h9a, rtab[k / 4], r, 8'h20 + 8'(k));
            run_cycle(k[1], k[0], 1'b1, 8'h6e ^ 8'(k), -1, none, 8'h80 + 8'(k * 3));
            run_cycle(1'b0, k[1], k[0], 8'h17, -1, none, 8'h55 ^ 8'(k));
        end
        run_cycle(1'b0, 1'b0, 1'b0, 8'h00, -1, none, 8'h00);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule